// File: doc/BRIEF.md
# Multicycle Five-Step RISC Core

This block is a small 32-bit processor core without a pipeline. Each instruction passes through five steps in strict order: fetch, decode with operand read, execute or address generation, memory or branch completion, and write-back. Temporary registers carry values from one step to the next. These are the instruction word, the sequential next PC, the two operands, the extended immediate, the ALU result, the loaded word and the branch condition. One memory request port serves both instruction fetches and data accesses.

The memory port is a valid/ready request channel. The core raises `mem_req_valid` and holds the address, write flag and write data steady until `mem_req_ready` is seen high at a clock edge. Memory may apply back-pressure for any number of cycles. For an accepted read, the memory returns the word on `mem_rdata` in the cycle that follows the accepting edge. The core accepts no back-pressure on that read data. A one-cycle `retire` pulse and a read-only debug port into the register file let a testbench follow the architectural state after every instruction.

Instruction fields are: opcode in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11, function code in 5:0 and immediate in 15:0. The immediate is always sign-extended.

Top module: `mc_core`

## Requirements
- R1: Fetch reads memory at the current PC. Any instruction that does not branch leaves PC at the old PC plus 4 when it retires.
- R2: Opcode 0x00 selects a register operation whose result goes to rd. Function codes: 0x20 add, 0x22 subtract (rs minus rt), 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0).
- R3: Opcodes 0x08 add, 0x0C and, 0x0D or and 0x0A signed set-less-than combine rs with the sign-extended immediate. The result goes to rt.
- R4: Opcode 0x23 loads the word at rs plus the sign-extended immediate into rt.
- R5: Opcode 0x2B writes rt to memory at rs plus the sign-extended immediate. It writes no register.
- R6: Opcode 0x04 branches when rs equals zero. The target is PC + 4 + (sign-extended immediate shifted left by 2). Otherwise the next PC is PC + 4. The rt field is ignored.
- R7: Register 0 always reads as zero. Writes to it have no effect.
- R8: An unknown opcode, or opcode 0x00 with an unknown function code, acts as a no-op: no register or memory changes, and the next PC is PC + 4.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with address, write flag and write data unchanged. Read data is taken from `mem_rdata` one cycle after the accepting edge.
- R10: `retire` is high for exactly one cycle per instruction. In that cycle `pc_o` already shows the next PC and the register file holds the result.
- R11: Reset (active low, asynchronous) sets PC to `RESET_PC` (default 0), clears all registers and holds `retire` low.
- R12: PC changes only at the edge that completes the memory step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request at this edge |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Byte address, word aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after an accepted read |
| retire | output | 1 | One-cycle pulse when an instruction completes |
| pc_o | output | 32 | Current program counter |
| dbg_sel | input | 5 | Debug register select |
| dbg_val | output | 32 | Value of the selected register |

## Verification
Assertions check on every cycle that a stalled request stays stable and that PC stays word aligned. They also check that PC moves only at memory-step completion, that retire never lasts two cycles and that register 0 stays zero. Only the bench scenarios can show the arithmetic results, the sign extension, the load and store address arithmetic and the branch targets. The same holds for taken versus untaken branches, forward versus backward branches, and the no-op handling of unknown encodings. The bench runs all of these while the memory stalls irregularly.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XW   = 32;
  localparam int NREG = 32;
  localparam int RW   = $clog2(NREG);
  localparam int OPW  = 6;

  typedef enum logic [2:0] {
    ST_FETCH, ST_FWAIT, ST_DECODE, ST_EXEC, ST_MEM, ST_MWAIT, ST_WB
  } step_e;

  typedef enum logic [2:0] {K_RR, K_RI, K_LD, K_ST, K_BR, K_NOP} kind_e;

  typedef enum logic [2:0] {A_ADD, A_SUB, A_AND, A_OR, A_SLT} aluop_e;

  localparam logic [OPW-1:0] OP_REG  = 6'h00;
  localparam logic [OPW-1:0] OP_BRZ  = 6'h04;
  localparam logic [OPW-1:0] OP_ADDI = 6'h08;
  localparam logic [OPW-1:0] OP_SLTI = 6'h0A;
  localparam logic [OPW-1:0] OP_ANDI = 6'h0C;
  localparam logic [OPW-1:0] OP_ORI  = 6'h0D;
  localparam logic [OPW-1:0] OP_LW   = 6'h23;
  localparam logic [OPW-1:0] OP_SW   = 6'h2B;

  localparam logic [OPW-1:0] FN_ADD = 6'h20;
  localparam logic [OPW-1:0] FN_SUB = 6'h22;
  localparam logic [OPW-1:0] FN_AND = 6'h24;
  localparam logic [OPW-1:0] FN_OR  = 6'h25;
  localparam logic [OPW-1:0] FN_SLT = 6'h2A;
endpackage

// File: rtl/mc_decode.sv
module mc_decode
  import mc_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  input  logic [OPW-1:0] funct,
  output kind_e          kind,
  output aluop_e         op
);
  always_comb begin
    kind = K_NOP;
    op   = A_ADD;
    case (opcode)
      OP_REG: begin
        kind = K_RR;
        case (funct)
          FN_ADD:  op = A_ADD;
          FN_SUB:  op = A_SUB;
          FN_AND:  op = A_AND;
          FN_OR:   op = A_OR;
          FN_SLT:  op = A_SLT;
          default: kind = K_NOP;
        endcase
      end
      OP_ADDI: begin kind = K_RI; op = A_ADD; end
      OP_SLTI: begin kind = K_RI; op = A_SLT; end
      OP_ANDI: begin kind = K_RI; op = A_AND; end
      OP_ORI:  begin kind = K_RI; op = A_OR;  end
      OP_LW:   kind = K_LD;
      OP_SW:   kind = K_ST;
      OP_BRZ:  kind = K_BR;
      default: kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  aluop_e       op,
  output logic [W-1:0] r
);
  always_comb begin
    case (op)
      A_ADD:   r = x + y;
      A_SUB:   r = x - y;
      A_AND:   r = x & y;
      A_OR:    r = x | y;
      A_SLT:   r = {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
      default: r = '0;
    endcase
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter  int N  = 32,
  parameter  int W  = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data,
  input  logic [AW-1:0] rc_addr,
  output logic [W-1:0]  rc_data
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];
  assign rc_data = regs[rc_addr];

  // R7
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == '0) |=> (regs[0] == '0));
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [XW-1:0] mem_req_addr,
  output logic [XW-1:0] mem_req_wdata,
  input  logic [XW-1:0] mem_rdata,
  output logic          retire,
  output logic [XW-1:0] pc_o,
  input  logic [RW-1:0] dbg_sel,
  output logic [XW-1:0] dbg_val
);
  localparam int IMW = 16;

  step_e         step;
  logic [XW-1:0] pc, npc, ir, opa, opb, imm, alu_q, lmd;
  logic          cond, retire_q;

  kind_e         kind;
  aluop_e        aop;
  logic [XW-1:0] ra_val, rb_val, alu_x, alu_y, alu_r;
  logic [RW-1:0] rs_f, rt_f, rd_f, wb_addr;
  logic          is_mem, mem_done, finish_now, wb_en;

  assign rs_f = ir[25:21];
  assign rt_f = ir[20:16];
  assign rd_f = ir[15:11];

  mc_decode u_dec (
    .opcode (ir[31:26]),
    .funct  (ir[5:0]),
    .kind   (kind),
    .op     (aop)
  );

  assign wb_en   = (step == ST_WB);
  assign wb_addr = (kind == K_RR) ? rd_f : rt_f;

  mc_regfile #(.N(NREG), .W(XW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wb_en),
    .waddr   (wb_addr),
    .wdata   ((kind == K_LD) ? lmd : alu_q),
    .ra_addr (rs_f),
    .ra_data (ra_val),
    .rb_addr (rt_f),
    .rb_data (rb_val),
    .rc_addr (dbg_sel),
    .rc_data (dbg_val)
  );

  // execute operand selection: branch target uses NPC and word-scaled offset
  assign alu_x = (kind == K_BR) ? npc : opa;
  assign alu_y = (kind == K_RR) ? opb :
                 (kind == K_BR) ? {imm[XW-3:0], 2'b00} : imm;

  mc_alu #(.W(XW)) u_alu (
    .x  (alu_x),
    .y  (alu_y),
    .op ((kind == K_RR || kind == K_RI) ? aop : A_ADD),
    .r  (alu_r)
  );

  assign is_mem        = (kind == K_LD) || (kind == K_ST);
  assign mem_req_valid = (step == ST_FETCH) || (step == ST_MEM && is_mem);
  assign mem_req_we    = (step == ST_MEM) && (kind == K_ST);
  assign mem_req_addr  = (step == ST_FETCH) ? pc : alu_q;
  assign mem_req_wdata = opb;
  assign mem_done      = (step == ST_MEM) && (!is_mem || mem_req_ready);
  assign finish_now    = (step == ST_WB) ||
                         (mem_done && (kind == K_ST || kind == K_BR || kind == K_NOP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= ST_FETCH;
      pc       <= RESET_PC;
      npc      <= '0;
      ir       <= '0;
      opa      <= '0;
      opb      <= '0;
      imm      <= '0;
      alu_q    <= '0;
      lmd      <= '0;
      cond     <= 1'b0;
      retire_q <= 1'b0;
    end else begin
      retire_q <= finish_now;
      case (step)
        ST_FETCH:  if (mem_req_ready) step <= ST_FWAIT;
        ST_FWAIT: begin
          ir   <= mem_rdata;
          npc  <= pc + 32'd4;
          step <= ST_DECODE;
        end
        ST_DECODE: begin
          opa  <= ra_val;
          opb  <= rb_val;
          imm  <= {{(XW-IMW){ir[IMW-1]}}, ir[IMW-1:0]};
          step <= ST_EXEC;
        end
        ST_EXEC: begin
          alu_q <= alu_r;
          cond  <= (opa == '0);
          step  <= ST_MEM;
        end
        ST_MEM: if (mem_done) begin
          pc <= (kind == K_BR && cond) ? alu_q : npc;
          if (kind == K_LD)                       step <= ST_MWAIT;
          else if (kind == K_RR || kind == K_RI)  step <= ST_WB;
          else                                    step <= ST_FETCH;
        end
        ST_MWAIT: begin
          lmd  <= mem_rdata;
          step <= ST_WB;
        end
        ST_WB:     step <= ST_FETCH;
        default:   step <= ST_FETCH;
      endcase
    end
  end

  assign retire = retire_q;
  assign pc_o   = pc;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_we) && $stable(mem_req_wdata)));

  // R1
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[1:0] == 2'b00);

  // R12
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step != ST_MEM) |=> $stable(pc_o));

  // R10
  retire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !retire);
endmodule

// File: tb/sim_mc_core.sv
module sim_mc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req_valid, mem_req_ready, mem_req_we, retire;
  logic [31:0] mem_req_addr, mem_req_wdata, pc_o, dbg_val;
  logic [31:0] mem_rdata = '0;
  logic [4:0]  dbg_sel = '0;

  always #5 clk = ~clk;

  mc_core u0 (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rdata(mem_rdata),
    .retire(retire), .pc_o(pc_o), .dbg_sel(dbg_sel), .dbg_val(dbg_val)
  );

  // memory model with irregular back-pressure
  logic [31:0] mem [256];
  logic [7:0]  cyc = '0;
  logic        stall_on = 1'b1;
  assign mem_req_ready = !stall_on || (cyc[0] ^ cyc[2]);

  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) mem[mem_req_addr[9:2]] <= mem_req_wdata;
      else            mem_rdata <= mem[mem_req_addr[9:2]];
    end
  end

  // request stability observer
  int          hold_bad = 0, stalls = 0;
  logic        pend = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr = '0, p_wd = '0;
  always @(negedge clk) begin
    if (!rst_n) pend = 1'b0;
    else begin
      if (pend && (!mem_req_valid || mem_req_addr != p_addr ||
                   mem_req_we != p_we || mem_req_wdata != p_wd)) hold_bad++;
      pend = mem_req_valid && !mem_req_ready;
      if (pend) stalls++;
      p_addr = mem_req_addr; p_we = mem_req_we; p_wd = mem_req_wdata;
    end
  end

  int total = 0, bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(input int s, input int t, input int d, input logic [5:0] f);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'h00, f};
  endfunction

  function automatic logic [31:0] ri(input logic [5:0] op, input int s, input int t, input logic [15:0] im);
    return {op, 5'(s), 5'(t), im};
  endfunction

  // {req tag, instruction, checked register, expected value, expected next pc}
  localparam int NV = 21;
  localparam logic [104:0] VEC [NV] = '{
    {4'd1,  ri(6'h08, 0, 1, 16'h0005), 5'd1,  32'h5,        32'd4},   // R1 R3
    {4'd3,  ri(6'h08, 0, 2, 16'hFFFD), 5'd2,  32'hFFFFFFFD, 32'd8},   // R3
    {4'd2,  rr(1, 2, 3, 6'h20),        5'd3,  32'h2,        32'd12},  // R2
    {4'd2,  rr(1, 2, 4, 6'h22),        5'd4,  32'h8,        32'd16},  // R2
    {4'd2,  rr(1, 2, 5, 6'h24),        5'd5,  32'h5,        32'd20},  // R2
    {4'd2,  rr(1, 2, 6, 6'h25),        5'd6,  32'hFFFFFFFD, 32'd24},  // R2
    {4'd2,  rr(2, 1, 7, 6'h2A),        5'd7,  32'h1,        32'd28},  // R2
    {4'd2,  rr(1, 2, 8, 6'h2A),        5'd8,  32'h0,        32'd32},  // R2
    {4'd7,  ri(6'h08, 0, 0, 16'h0007), 5'd0,  32'h0,        32'd36},  // R7
    {4'd3,  ri(6'h0D, 1, 9, 16'h0100), 5'd9,  32'h105,      32'd40},  // R3
    {4'd3,  ri(6'h0C, 2, 10, 16'h000F),5'd10, 32'hD,        32'd44},  // R3
    {4'd3,  ri(6'h0A, 2, 11, 16'h0000),5'd11, 32'h1,        32'd48},  // R3
    {4'd5,  ri(6'h2B, 0, 1, 16'h0100), 5'd1,  32'h5,        32'd52},  // R5
    {4'd4,  ri(6'h23, 0, 12, 16'h0100),5'd12, 32'h5,        32'd56},  // R4
    {4'd4,  ri(6'h23, 4, 13, 16'h00FC),5'd13, 32'hCAFE0001, 32'd60},  // R4
    {4'd6,  ri(6'h04, 8, 0, 16'h0002), 5'd8,  32'h0,        32'd72},  // R6 taken forward
    {4'd6,  ri(6'h04, 1, 0, 16'h0005), 5'd1,  32'h5,        32'd76},  // R6 not taken
    {4'd8,  ri(6'h3F, 1, 1, 16'h1234), 5'd1,  32'h5,        32'd80},  // R8 unknown opcode
    {4'd6,  ri(6'h04, 0, 0, 16'hFFEC), 5'd0,  32'h0,        32'd4},   // R6 taken backward
    {4'd1,  ri(6'h08, 1, 14, 16'hFFF9),5'd14, 32'hFFFFFFFE, 32'd8},   // R1 refetch
    {4'd8,  rr(1, 1, 15, 6'h3F),       5'd15, 32'h0,        32'd12}   // R8 unknown funct
  };

  task automatic wait_retire();
    int n = 0;
    @(negedge clk);
    while (!retire && n < 300) begin @(negedge clk); n++; end
    if (!retire) begin
      total++; bad++;
      $display("FAIL R10 actual=timeout expected=retire");
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[65] = 32'hCAFE0001;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 pc", pc_o, 32'h0);
    check("R11 retire", {31'h0, retire}, 32'h0);
    dbg_sel = 5'd1;
    #1 check("R11 reg", dbg_val, 32'h0);
    mem[0] = VEC[0][100:69];
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      mem[pc_o[9:2]] = VEC[i][100:69];
      wait_retire();
      dbg_sel = VEC[i][68:64];
      #1;
      check($sformatf("R%0d reg v%0d", VEC[i][104:101], i), dbg_val, VEC[i][63:32]);
      check($sformatf("R%0d pc v%0d", VEC[i][104:101], i), pc_o, VEC[i][31:0]);
      check("R10 pulse", {31'h0, retire}, 32'h1);
    end
    // R5 store landed in memory
    check("R5 mem", mem[64], 32'h5);
    // R9 request held under back-pressure
    check("R9 hold", hold_bad, 0);
    check("R9 stalls seen", {31'h0, stalls > 0}, 32'h1);
    // R11 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    dbg_sel = 5'd1;
    #1;
    check("R11 pc mid", pc_o, 32'h0);
    check("R11 reg mid", dbg_val, 32'h0);
    check("R11 retire mid", {31'h0, retire}, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule